// File: doc/BRIEF.md
# DS2 Tributary Demultiplexer with Majority Destuffing

The block accepts a serial DS2 bit stream, qualified by a per-bit enable, and splits it into four DS1 tributary streams. Each tributary has its own data output and a one-cycle valid strobe. An upstream framer supplies two signals. The first is a pulse on the first bit of each frame, which aligns the position counter. The second is a level that says whether the frame is currently held.

The frame is 1176 bits long, organised as four subframes of 294 bits. Each subframe contains six blocks of 49 bits, and each block is one overhead bit followed by 48 payload bits. The payload bits rotate across the four tributaries. Inside each subframe, three overhead bits are stuff-control bits. A two-of-three vote on them decides whether that subframe's stuff-opportunity bit is payload or padding. If it is padding, it is dropped.

The X-bit is lifted out of every frame onto a separate output. While the framer reports loss of frame, every tributary whose alarm-enable bit is set carries all ones. The valid strobes keep their normal timing during that time, so destuffing continues unchanged.

Top module: `ds2_demux`

## Requirements
- R1: While `rst_n` is low, `trib_valid`, `trib_data`, `x_stb` and `x_data` are all zero.
- R2: Bit positions run 0..1175 and wrap to 0 without a sync pulse. Position p has subframe p/294, block (p mod 294)/49 and in-block index p mod 49. In-block index 0 is an overhead bit.
- R3: In-block index k (1..48) is payload for tributary (k-1) mod 4. One cycle after that bit's enabled clock, the tributary's `trib_valid` bit pulses and its `trib_data` bit shows the bit. `trib_data` holds its value between strobes.
- R4: An overhead bit never raises any `trib_valid` bit.
- R5: The stuff-control bits are the overhead bits of blocks 1, 3 and 4 of each subframe. The stuff opportunity of tributary N is in-block index N+1 of block 5 in subframe N. If two or three of that subframe's control bits are 1, the opportunity bit is dropped and no strobe is given. Otherwise it is delivered as payload.
- R6: The overhead bit of block 0 in subframe 3 is the X-bit. One cycle after it arrives, `x_data` takes its value and `x_stb` pulses for one cycle.
- R7: For a payload bit that arrives while `frame_ok` is low, tributary n delivers 1 when `ais_en[n]` is set, and delivers the received bit otherwise. Strobe timing and stuff removal are unaffected.
- R8: In a cycle with `bit_en` low, the position does not advance, `sync_in` is ignored, and no strobe is produced in the following cycle.
- R9: An enabled bit with `sync_in` high is taken as position 0 of a new frame, wherever the counter stood.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Marks a cycle that carries a DS2 bit |
| bit_in | input | 1 | Serial DS2 bit |
| sync_in | input | 1 | Frame-start pulse from the framer, first bit of a frame |
| frame_ok | input | 1 | High while the framer holds frame alignment |
| ais_en | input | 4 | Per-tributary all-ones insertion enable on loss of frame |
| trib_data | output | 4 | Tributary data bits |
| trib_valid | output | 4 | Tributary data strobes |
| x_data | output | 1 | Last extracted X-bit |
| x_stb | output | 1 | Pulses when `x_data` is refreshed |

## Verification
The assertions check structural rules on every cycle. At most one tributary strobes at a time. Overhead bits and dropped stuff bits produce no strobe. Idle cycles freeze the position and yield no strobe. The counter wraps and resynchronises to the right position. The vote counter never sees more than three control bits per subframe. Alarm insertion always yields a one.

Whether each payload bit reaches the right tributary in the right order, whether a vote of exactly one or exactly two control bits is decided correctly, and whether the X-bit comes from the right subframe can only be shown by the bench's reference model. It runs over continuous and gapped enables, mid-frame resynchronisation, and loss of frame with mixed alarm masks.

// File: rtl/ds2_demux_pkg.sv
package ds2_demux_pkg;

  // Frame geometry
  localparam int unsigned TRIBS        = 4;
  localparam int unsigned SUBFRAMES    = 4;
  localparam int unsigned BLOCKS       = 6;
  localparam int unsigned DATA_PER_BLK = 48;
  localparam int unsigned BLK_LEN      = DATA_PER_BLK + 1;

  localparam int unsigned BB_W   = $clog2(BLK_LEN);
  localparam int unsigned BLK_W  = $clog2(BLOCKS);
  localparam int unsigned SUB_W  = $clog2(SUBFRAMES);
  localparam int unsigned TRIB_W = $clog2(TRIBS);

  // Overhead roles
  localparam int unsigned M_BLK     = 0;
  localparam int unsigned X_SUB     = SUBFRAMES - 1;
  localparam int unsigned STUFF_BLK = BLOCKS - 1;
  // One bit per block index: set where the overhead bit is a stuff-control bit
  localparam logic [2**BLK_W-1:0] CTRL_BLK_MASK = (2**BLK_W)'(8'b0001_1010);

  // Vote counter
  localparam int unsigned VOTE_W   = 2;
  localparam int unsigned VOTE_MAJ = 2;

  typedef struct packed {
    logic [SUB_W-1:0] sub;
    logic [BLK_W-1:0] blk;
    logic [BB_W-1:0]  bb;
  } ds2_pos_t;

  typedef struct packed {
    logic              oh;
    logic              m_bit;
    logic              c_bit;
    logic              x_bit;
    logic              stuff_opp;
    logic [TRIB_W-1:0] trib;
  } ds2_slot_t;

endpackage

// File: rtl/ds2_pos_counter.sv
module ds2_pos_counter
  import ds2_demux_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bit_en,
  input  logic      sync_in,
  output ds2_slot_t slot
);

  ds2_pos_t        pos_q;
  ds2_pos_t        pos_cur;
  ds2_pos_t        pos_nxt;
  logic [BB_W-1:0] didx;

  // Position of the bit presented in this cycle, and its successor
  always_comb begin
    pos_cur = sync_in ? '0 : pos_q;
    pos_nxt = pos_cur;
    if (pos_cur.bb == BB_W'(BLK_LEN - 1)) begin
      pos_nxt.bb = '0;
      if (pos_cur.blk == BLK_W'(BLOCKS - 1)) begin
        pos_nxt.blk = '0;
        if (pos_cur.sub == SUB_W'(SUBFRAMES - 1)) pos_nxt.sub = '0;
        else                                      pos_nxt.sub = pos_cur.sub + SUB_W'(1);
      end else begin
        pos_nxt.blk = pos_cur.blk + BLK_W'(1);
      end
    end else begin
      pos_nxt.bb = pos_cur.bb + BB_W'(1);
    end
  end

  // Slot decode
  always_comb begin
    didx           = pos_cur.bb - BB_W'(1);
    slot.oh        = (pos_cur.bb == '0);
    slot.m_bit     = slot.oh && (pos_cur.blk == BLK_W'(M_BLK));
    slot.c_bit     = slot.oh && CTRL_BLK_MASK[pos_cur.blk];
    slot.x_bit     = slot.m_bit && (pos_cur.sub == SUB_W'(X_SUB));
    slot.stuff_opp = !slot.oh && (pos_cur.blk == BLK_W'(STUFF_BLK))
                     && (didx == BB_W'(pos_cur.sub));
    slot.trib      = didx[TRIB_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos_q <= '0;
    else if (bit_en) pos_q <= pos_nxt;
  end

  // R2: last bit of the frame wraps to position 0
  a_r2_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !sync_in && pos_q.sub == SUB_W'(SUBFRAMES - 1)
     && pos_q.blk == BLK_W'(BLOCKS - 1) && pos_q.bb == BB_W'(BLK_LEN - 1))
    |=> (pos_q == '0));

  // R9: a sync bit is position 0, so the next bit is position 1
  a_r9_sync_realign: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && sync_in) |=> (pos_q.sub == '0 && pos_q.blk == '0 && pos_q.bb == BB_W'(1)));

  // R8: idle cycles freeze the position
  a_r8_pos_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(pos_q));

  a_r2_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q.bb < BB_W'(BLK_LEN)) && (pos_q.blk < BLK_W'(BLOCKS)));

endmodule

// File: rtl/ds2_stuff_vote.sv
module ds2_stuff_vote
  import ds2_demux_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic bit_in,
  input  logic m_bit,
  input  logic c_bit,
  output logic discard
);

  logic [VOTE_W-1:0] ones_q;
  logic [VOTE_W-1:0] ones_d;

  // Count control-bit ones; the subframe's first overhead bit clears the tally
  always_comb begin
    ones_d = ones_q;
    if (m_bit)                ones_d = '0;
    else if (c_bit && bit_in) ones_d = ones_q + VOTE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ones_q <= '0;
    else if (bit_en) ones_q <= ones_d;
  end

  assign discard = (ones_q >= VOTE_W'(VOTE_MAJ));

  // R5: no more than three control bits counted in a subframe
  a_r5_vote_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && c_bit && bit_in) |-> (ones_q != '1));

endmodule

// File: rtl/ds2_trib_lane.sv
module ds2_trib_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic bit_in,
  input  logic take,
  input  logic ais_force,
  output logic data_q,
  output logic valid_q
);

  logic load;
  logic data_d;
  logic valid_d;

  always_comb begin
    load    = bit_en && take;
    valid_d = load;
    data_d  = load ? (ais_force | bit_in) : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      data_q  <= data_d;
      valid_q <= valid_d;
    end
  end

  // R7: alarm insertion delivers a one on the strobe
  a_r7_ais_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && take && ais_force) |=> (valid_q && data_q));

  // R3: data is held between strobes
  a_r3_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_en && take) |=> (!valid_q && $stable(data_q)));

endmodule

// File: rtl/ds2_demux.sv
module ds2_demux
  import ds2_demux_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             bit_in,
  input  logic             sync_in,
  input  logic             frame_ok,
  input  logic [TRIBS-1:0] ais_en,
  output logic [TRIBS-1:0] trib_data,
  output logic [TRIBS-1:0] trib_valid,
  output logic             x_data,
  output logic             x_stb
);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  ds2_slot_t slot;
  logic      discard;

  ds2_pos_counter u_pos (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .bit_en  (bit_en),
    .sync_in (sync_in),
    .slot    (slot)
  );

  ds2_stuff_vote u_vote (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .bit_en  (bit_en),
    .bit_in  (bit_in),
    .m_bit   (slot.m_bit),
    .c_bit   (slot.c_bit),
    .discard (discard)
  );

  logic drop_bit;
  assign drop_bit = slot.stuff_opp && discard;

  for (genvar n = 0; n < TRIBS; n++) begin : g_lane
    logic take;
    logic ais_force;
    assign take      = !slot.oh && (slot.trib == TRIB_W'(n)) && !drop_bit;
    assign ais_force = !frame_ok && ais_en[n];

    ds2_trib_lane u_lane (
      .clk       (clk),
      .rst_n     (rst_n_int),
      .bit_en    (bit_en),
      .bit_in    (bit_in),
      .take      (take),
      .ais_force (ais_force),
      .data_q    (trib_data[n]),
      .valid_q   (trib_valid[n])
    );
  end

  // X-bit capture
  logic x_data_d;
  logic x_stb_d;

  always_comb begin
    x_stb_d  = bit_en && slot.x_bit;
    x_data_d = x_stb_d ? bit_in : x_data;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      x_data <= 1'b0;
      x_stb  <= 1'b0;
    end else begin
      x_data <= x_data_d;
      x_stb  <= x_stb_d;
    end
  end

  // R3: only one tributary strobes per bit
  a_r3_one_lane: assert property (@(posedge clk) disable iff (!rst_n_int)
    $onehot0(trib_valid));

  // R4: overhead bits give no strobe
  a_r4_oh_silent: assert property (@(posedge clk) disable iff (!rst_n_int)
    (bit_en && slot.oh) |=> (trib_valid == '0));

  // R5: a dropped stuff bit gives no strobe
  a_r5_stuff_drop: assert property (@(posedge clk) disable iff (!rst_n_int)
    (bit_en && slot.stuff_opp && discard) |=> (trib_valid == '0));

  // R6: the X-bit strobe never coincides with tributary data
  a_r6_x_alone: assert property (@(posedge clk) disable iff (!rst_n_int)
    x_stb |-> (trib_valid == '0));

  // R8: no strobe after an idle cycle
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n_int)
    !bit_en |=> (trib_valid == '0 && !x_stb));

endmodule

// File: tb/ds2_demux_tb.sv
module ds2_demux_tb;

  localparam int FRAME  = 1176;
  localparam int SUBLEN = 294;
  localparam int BLKLEN = 49;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_en, bit_in, sync_in, frame_ok;
  logic [3:0] ais_en;
  logic [3:0] trib_data, trib_valid;
  logic       x_data, x_stb;

  always #10 clk = ~clk;

  ds2_demux u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .sync_in(sync_in), .frame_ok(frame_ok), .ais_en(ais_en),
    .trib_data(trib_data), .trib_valid(trib_valid),
    .x_data(x_data), .x_stb(x_stb)
  );

  int         total = 0;
  int         bad = 0;
  int         ref_pos = 0;
  int         frame_cnt = 0;
  int         ones = 0;
  logic [3:0] exp_valid = '0;
  logic [3:0] exp_data = '0;
  logic       exp_x = 1'b0;
  logic       exp_xs = 1'b0;
  string      tag = "R1";

  task automatic chk(input string req, input string what,
                     input logic [3:0] act, input logic [3:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, expv);
    end
  endtask

  task automatic compare();
    chk(tag, "trib_valid", trib_valid, exp_valid);
    chk(tag, "trib_data", trib_data, exp_data);
    chk("R6", "x_stb", {3'b0, x_stb}, {3'b0, exp_xs});
    chk("R6", "x_data", {3'b0, x_data}, {3'b0, exp_x});
  endtask

  // One bit time: check the previous bit's results, drive a new bit, predict
  task automatic step(input bit en, input bit sy, input bit fok, input logic [3:0] ais);
    int   p, sub, blk, bb, d, t, pat, ci;
    logic b;
    bit   is_c;
    @(negedge clk);
    compare();
    p    = sy ? 0 : ref_pos;
    sub  = p / SUBLEN;
    blk  = (p % SUBLEN) / BLKLEN;
    bb   = p % BLKLEN;
    is_c = (bb == 0) && (blk == 1 || blk == 3 || blk == 4);
    if (is_c) begin
      ci  = (blk == 1) ? 0 : ((blk == 3) ? 1 : 2);
      pat = (frame_cnt * 3 + sub) % 8;
      b   = pat[ci];
    end else begin
      b = logic'($urandom % 2);
    end
    bit_en   = en;
    sync_in  = sy;
    frame_ok = fok;
    ais_en   = ais;
    bit_in   = b;
    exp_valid = '0;
    exp_xs    = 1'b0;
    if (!en) begin
      tag = "R8";
    end else begin
      tag = sy ? "R9" : ((p == 0) ? "R2" : "R3");
      if (bb == 0) begin
        if (tag == "R3") tag = "R4";
        if (blk == 0) ones = 0;
        if (is_c && b) ones++;
        if (blk == 0 && sub == 3) begin
          exp_x  = b;
          exp_xs = 1'b1;
        end
      end else begin
        d = bb - 1;
        t = d % 4;
        if (blk == 5 && d == sub && ones >= 2) begin
          if (tag == "R3") tag = "R5";
        end else begin
          exp_valid[t] = 1'b1;
          exp_data[t]  = (!fok && ais[t]) ? 1'b1 : b;
          if (tag == "R3")
            tag = (blk == 5 && d == sub) ? "R5" : ((!fok && ais[t]) ? "R7" : "R3");
        end
      end
      ref_pos = (p + 1) % FRAME;
      if (ref_pos == 0) frame_cnt++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog (all requirements): actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bit_en = 1'b0; bit_in = 1'b0; sync_in = 1'b0;
    frame_ok = 1'b1; ais_en = '0;
    repeat (3) @(negedge clk);
    // R1: outputs idle in reset
    chk("R1", "trib_valid", trib_valid, 4'b0);
    chk("R1", "trib_data", trib_data, 4'b0);
    chk("R1", "x_stb", {3'b0, x_stb}, 4'b0);
    chk("R1", "x_data", {3'b0, x_data}, 4'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Continuous bits, all vote patterns, free-running wrap (R2..R6)
    for (int i = 0; i < 3 * FRAME; i++) step(1'b1, i == 0, 1'b1, 4'b0000);
    // Gapped enables (R8)
    for (int i = 0; i < 2 * FRAME; i++) step(($urandom % 4) != 0, 1'b0, 1'b1, 4'b0000);
    // Loss of frame with mixed alarm mask (R7)
    for (int i = 0; i < FRAME; i++) step(1'b1, 1'b0, 1'b0, 4'b0101);
    for (int i = 0; i < FRAME; i++) step(($urandom % 3) != 0, 1'b0, 1'b0, 4'b1010);
    // Alarm mask set while in frame has no effect (R7)
    for (int i = 0; i < FRAME / 2; i++) step(1'b1, 1'b0, 1'b1, 4'b1111);
    // Sync arriving mid-frame realigns (R9)
    for (int i = 0; i < 500; i++) step(1'b1, 1'b0, 1'b1, 4'b0000);
    step(1'b1, 1'b1, 1'b1, 4'b0000);
    // Sync while idle is ignored (R8)
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 1'b1, 4'b0000);
    for (int i = 0; i < 2 * FRAME; i++) step(1'b1, 1'b0, 1'b1, 4'b0000);
    step(1'b0, 1'b0, 1'b1, 4'b0000);
    step(1'b0, 1'b0, 1'b1, 4'b0000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule